// File: doc/BRIEF.md
# Switchable-Depth Register Pipeline

This block is a datapath pipeline of ten register stages whose effective depth can be chosen at run time. When the deep setting is active, every stage registers its result and a word needs ten clock edges to reach the output. This setting suits fast clocks, where each stage has only a short slice of logic to settle in. When the shallow setting is active, the registers of the even-numbered stages become transparent. A 2:1 multiplexer then forwards each such stage's combinational result in place of its register, so the same logic completes in five edges. This setting keeps latency low when the clock is slowed down.

Each stage adds its own 1-based index to the word passing through it. This placeholder operation lets the datapath be checked: the output always equals the input plus 55, modulo 2^WIDTH, whichever setting is active. A valid flag travels with every word through the same registers and multiplexers. A requested change of setting is only applied on a clock edge at which no word is in flight, and the block reports that condition on its drained output.

Top module: `flex_depth_pipe`

## Requirements
- R1: With the deep setting active, a word accepted on clock edge E (in_valid high) appears with out_valid high in the cycle after edge E+9, which is ten edges counting E.
- R2: With the shallow setting active, the registers of stages 2, 4, 6, 8 and 10 are bypassed. A word accepted on edge E appears in the cycle after edge E+4, which is five edges counting E.
- R3: Every word leaves with out_data equal to in_data + 55 modulo 2^32, in either setting, including inputs that wrap around.
- R4: Words sent back to back or with gaps each produce exactly one output, in order. out_valid stays low in every cycle where no word is due.
- R5: drained is high exactly when no stage register holds a valid word, and out_valid is never high while drained is high.
- R6: shallow_req (1 selects shallow, 0 selects deep) is taken into the active setting only on an edge where drained is high. A change requested while words are in flight is held back until the pipeline drains. Words sent during the wait keep the latency of the old setting.
- R7: A synchronous active-low reset clears every valid flag and selects the deep setting. In the cycle after a reset edge, out_valid is low and drained is high, and words that were in flight never appear.
- R8: in_data is ignored while in_valid is low: no output is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_data as a word to accept |
| in_data | input | WIDTH | Input word |
| shallow_req | input | 1 | Requested setting: 1 shallow (five edges), 0 deep (ten edges) |
| out_valid | output | 1 | Marks out_data as a finished word |
| out_data | output | WIDTH | Input word plus 55 |
| drained | output | 1 | High when no word is in flight |

## Verification
A word driven before edge E is due at the output in the cycle after edge E+9 in deep operation, or after edge E+4 in shallow operation. The bench keeps its own record of the active setting and recomputes it from shallow_req and its own drained prediction. It uses that record to decide the due cycle of each word and files the expected sum under that cycle. At every falling edge it compares out_valid, out_data and drained with that record. Mode requests that arrive in mid-stream, requests that coincide with a new word on a drained pipeline, and a reset with words in flight are each stepped through in this way.

// File: rtl/fdp_pkg.sv
`timescale 1ns/1ps
// Package fdp_pkg
// Shared types and elaboration-time helpers for the switchable-depth pipeline.
// Assumes stages are numbered from 1 at the input side.
package fdp_pkg;

    // Active depth setting of the pipeline.
    typedef enum logic {
        DEPTH_FULL = 1'b0,
        DEPTH_HALF = 1'b1
    } depth_e;

    // True for stages whose register may be made transparent (even numbers).
    function automatic bit stage_bypassable(input int unsigned idx);
        return (idx % 2) == 0;
    endfunction

endpackage

// File: rtl/fdp_stage.sv
`timescale 1ns/1ps
// Module fdp_stage
// One pipeline stage: adds a fixed constant to the word, then registers it.
// When bypass is high, the register is skipped. Its combinational input is
// forwarded instead, and the held valid flag is loaded with zero so that no
// stale copy remains once bypass is released.
// Assumes bypass changes only while no valid word is held upstream.
module fdp_stage #(
    parameter int WIDTH = 32,
    parameter int ADD   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_dat,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_dat,
    output logic             held_vld
);

    logic [WIDTH-1:0] sum;
    logic             vld_q;
    logic [WIDTH-1:0] dat_q;

    // Stage operation: add this stage's constant.
    assign sum = in_dat + WIDTH'(ADD);

    // Valid flag register, cleared by reset and kept empty while bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_vld & ~bypass;
    end

    // Data register, no reset needed since valid qualifies it.
    always_ff @(posedge clk) begin
        dat_q <= sum;
    end

    // Bypass multiplexer: register output or its combinational input.
    assign out_vld  = bypass ? in_vld : vld_q;
    assign out_dat  = bypass ? sum    : dat_q;
    assign held_vld = vld_q;

endmodule

// File: rtl/fdp_mode_ctrl.sv
`timescale 1ns/1ps
// Module fdp_mode_ctrl
// Holds the active depth setting. A requested setting is taken only on an
// edge where the pipeline is empty, so no word ever sees two settings.
// Assumes drained reflects the stage registers before the edge.
module fdp_mode_ctrl
    import fdp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_half,
    input  logic   drained,
    output depth_e mode
);

    // Setting register: reset to deep, update only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= DEPTH_FULL;
        else if (drained) mode <= req_half ? DEPTH_HALF : DEPTH_FULL;
    end

endmodule

// File: rtl/flex_depth_pipe.sv
`timescale 1ns/1ps
// Module flex_depth_pipe
// Pipeline of STAGES stages. Stage k adds k to the word. In shallow setting
// the even-numbered stages forward combinationally, halving latency.
// Assumes STAGES is even so that the last stage is bypassable.
module flex_depth_pipe
    import fdp_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int STAGES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic             shallow_req,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             drained
);

    logic [STAGES:0]  vld_chain;
    logic [WIDTH-1:0] dat_chain [STAGES+1];
    logic [STAGES-1:0] held;
    depth_e           mode_q;
    logic             half;

    // Entry point of the chain.
    assign vld_chain[0] = in_valid;
    assign dat_chain[0] = in_data;
    assign half         = (mode_q == DEPTH_HALF);

    // Build the stage chain; only even-numbered stages see the bypass.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic skip;
        if (stage_bypassable(k + 1)) begin : g_skip
            assign skip = half;
        end else begin : g_keep
            assign skip = 1'b0;
        end
        fdp_stage #(
            .WIDTH (WIDTH),
            .ADD   (k + 1)
        ) u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .bypass   (skip),
            .in_vld   (vld_chain[k]),
            .in_dat   (dat_chain[k]),
            .out_vld  (vld_chain[k+1]),
            .out_dat  (dat_chain[k+1]),
            .held_vld (held[k])
        );
    end

    // Empty when no stage register holds a valid word.
    assign drained = ~|held;

    fdp_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_half (shallow_req),
        .drained  (drained),
        .mode     (mode_q)
    );

    // Result leaves from the last stage, through its bypass if active.
    assign out_valid = vld_chain[STAGES];
    assign out_data  = dat_chain[STAGES];

endmodule

// File: rtl/fdp_chk.sv
`timescale 1ns/1ps
// Module fdp_chk
// Property checker bound to flex_depth_pipe. It relates the output valid,
// the drained flag, the active setting and the stage register valids.
module fdp_chk
    import fdp_pkg::*;
#(
    parameter int STAGES = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              drained,
    input depth_e            mode,
    input logic [STAGES-1:0] held
);

    logic [STAGES-1:0] skip_mask;

    // Mask of stages whose register is transparent in shallow setting.
    always_comb begin
        for (int i = 0; i < STAGES; i++) skip_mask[i] = stage_bypassable(i + 1);
    end

    // R5
    drained_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !out_valid);

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drained |=> $stable(mode));

    // R1
    full_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DEPTH_FULL) |=> (out_valid == $past(held[STAGES-2])));

    // R2
    half_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DEPTH_HALF) |-> (out_valid == held[STAGES-2]));

    // R2
    half_skip_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DEPTH_HALF) |-> ((held & skip_mask) == '0));

endmodule

bind flex_depth_pipe fdp_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .drained   (drained),
    .mode      (mode_q),
    .held      (held)
);

// File: tb/sim_flex_depth_pipe.sv
`timescale 1ns/1ps
// Bench for flex_depth_pipe: sweeps streams and gaps in both settings,
// mid-stream setting requests and a reset with words in flight.
module sim_flex_depth_pipe;

    localparam int N        = 10;
    localparam int FULL_LAT = N;
    localparam int HALF_LAT = N / 2;
    localparam logic [31:0] OFFSET = 32'(N * (N + 1) / 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        shallow_req = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        drained;

    flex_depth_pipe #(.WIDTH(32), .STAGES(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .shallow_req (shallow_req),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .drained     (drained)
    );

    always #10 clk = ~clk;

    int          s = 0;
    int          checks = 0;
    int          failures = 0;
    bit          done = 0;
    logic [31:0] exp_d [int];
    int          exp_tag [int];
    int          lastdue = -1;
    bit          model_half = 0;
    bit          chk_on = 0;
    bit          post_rst = 0;

    function automatic string tag_name(input int t);
        case (t)
            1:       return "R1";
            2:       return "R2";
            default: return "R6";
        endcase
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s sample %0d: actual=%b expected=%b", tag, s, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s sample %0d: actual=%h expected=%h", tag, s, act, exp);
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next inputs.
    task automatic step(input bit r, input bit v, input logic [31:0] d, input bit m);
        bit due;
        bit dr;
        int lat;
        @(negedge clk);
        s++;
        due = exp_d.exists(s);
        dr  = (s > lastdue);
        if (chk_on) begin
            if (post_rst) begin
                check_bit("R7 out_valid after reset", out_valid, 1'b0);
                check_bit("R7 drained after reset", drained, 1'b1);
            end else begin
                if (due) begin
                    check_bit({tag_name(exp_tag[s]), " out_valid latency"}, out_valid, 1'b1);
                    check_word("R3 out_data", out_data, exp_d[s]);
                    exp_d.delete(s);
                end else begin
                    check_bit(dr ? "R8 out_valid idle" : "R4 out_valid gap", out_valid, 1'b0);
                end
                check_bit("R5 drained", drained, dr);
            end
        end
        post_rst    = 0;
        rst_n       = r;
        in_valid    = v;
        in_data     = d;
        shallow_req = m;
        if (!r) begin
            exp_d.delete();
            exp_tag.delete();
            lastdue    = -1;
            model_half = 0;
            post_rst   = 1;
            chk_on     = 1;
        end else begin
            if (dr) model_half = m;
            if (v) begin
                lat = model_half ? HALF_LAT : FULL_LAT;
                exp_d[s + lat]   = d + OFFSET;
                exp_tag[s + lat] = (m != model_half) ? 6 : (model_half ? 2 : 1);
                if (s + lat > lastdue) lastdue = s + lat;
            end
        end
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i)
            0:       return 32'h0000_0000;
            1:       return 32'hFFFF_FFFF;
            2:       return 32'hFFFF_FFC9;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R1: deep stream, back to back, with wrap values
        for (int i = 0; i < 40; i++) step(1, 1, pick(i), 0);
        repeat (14) step(1, 0, $urandom, 0);
        // R6: shallow requested in mid-stream, held until drained
        for (int i = 0; i < 30; i++) step(1, (i < 10) || (i % 2 == 0), $urandom, i >= 10);
        repeat (14) step(1, 0, $urandom, 1);
        // R2: shallow stream with a gap pattern
        for (int i = 0; i < 40; i++) step(1, (i % 3) != 2, pick(i), 1);
        repeat (8) step(1, 0, $urandom, 1);
        // R6: deep requested in mid-stream
        for (int i = 0; i < 20; i++) step(1, 1, $urandom, i >= 5);
        repeat (14) step(1, 0, $urandom, 0);
        // R4: sparse deep traffic
        for (int i = 0; i < 30; i++) step(1, (i % 4) == 0, $urandom, 0);
        repeat (12) step(1, 0, $urandom, 0);
        // R6: setting change on the same edge as a word on an empty pipe
        for (int k = 0; k < 6; k++) begin
            step(1, 1, $urandom, k[0]);
            repeat (12) step(1, 0, $urandom, k[0]);
        end
        // R7: reset with words in flight
        for (int i = 0; i < 6; i++) step(1, 1, $urandom, 0);
        step(0, 0, $urandom, 0);
        repeat (12) step(1, 0, $urandom, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule